// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is one timer channel for a peripheral subsystem. Software sets it up through a small word-indexed register port. It holds a programmed limit and a control byte. On each prescaled step of an external base-rate tick it counts down by one. When a count ends it raises a sticky raw interrupt flag. The flag drives a level interrupt line whenever the interrupt-enable control bit is set.

There are three counting behaviours, chosen by two control bits:

- **Free-running.** The count restarts at the full 16-bit or 32-bit range.
- **Periodic.** The count restarts from the programmed limit.
- **One-shot.** The count halts at zero after its first expiry.

The limit can be written in two ways. One write restarts the count at once. The other write changes only the value used at the next restart. A 2-bit field divides the tick rate by 1, 16 or 256.

Control byte fields, by bit position:

| Bit(s) | Field |
|---|---|
| 0 | one-shot |
| 1 | 32-bit width (0 selects 16-bit) |
| 3:2 | prescale select |
| 5 | interrupt enable |
| 6 | periodic |
| 7 | run enable |

Register word indices:

| Index | Register |
|---|---|
| 0 | immediate load |
| 1 | current count |
| 2 | control |
| 3 | interrupt clear |
| 4 | raw status |
| 5 | masked status |
| 6 | deferred load |

Top module: `cntdn_timer`

## Requirements
- R1: Synchronous active-low reset gives control = 0x20 (interrupt enable only, not running), count = 0, raw flag = 0 and irq_o = 0.
- R2: A write to index 0 stores the limit and, in the same edge, loads the count with the active reload value. Reads of index 0 and index 6 both return the stored limit.
- R3: A write to index 6 stores the limit but leaves the current count untouched. The new limit is first used at the next expiry reload.
- R4: Writes to index 1 (current count) have no effect on the count.
- R5: While running, every prescaled step lowers the count by one. A step taken while the active count is 1 or 0 is an expiry. In periodic mode (bit 6 = 1, bit 0 = 0) an expiry reloads the stored limit, so a limit L ≥ 1 expires every L steps.
- R6: With bits 0 and 6 both clear (free-running), every reload uses 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, whatever the stored limit.
- R7: In one-shot mode (bit 0 = 1) the first expiry leaves the count at 0. No further steps change the count or raise the flag until the next load or control write.
- R8: Prescale field bits 3:2 select the step rate: 00 = every tick, 01 = every 16th tick, 10 = every 256th tick, 11 = every tick. Any control write restarts the prescale phase.
- R9: An expiry sets the raw flag (index 4, bit 0). Any write to index 3 clears it. An expiry in the same cycle as a clear leaves the flag set.
- R10: Masked status (index 5, bit 0) and irq_o both equal the raw flag AND control bit 5.
- R11: In 16-bit mode only the low 16 bits of the limit are reloaded, and the count reads back with bits 31:16 as zero. The limit itself reads back in full.
- R12: A control write with bit 7 set reloads the count from the new configuration. A control write with bit 7 clear leaves the count unchanged.
- R13: Reads of index 3 and index 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base-rate tick, one clock cycle wide per tick |
| addr_i | input | 3 | Register word index |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational from state |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a free-running 16-bit expiry. The bench gets there by holding the tick input high for 65,535 consecutive cycles, then checking that the count returns to 0xFFFF rather than to the small programmed limit.

A second hard case is an expiry landing in the very cycle of a flag-clear write. The bench sets up a periodic limit of 1, so every step expires, then raises the tick and the clear write on the same clock edge.

Restarting the prescale phase on a control write is exposed in three steps:
1. Run part of a divide-by-16 phase.
2. Rewrite the control register.
3. Confirm that the next 15 ticks still produce no step.

// File: rtl/cntdn_pkg.sv
// Package: shared constants for the down-counter timer.
// Holds control-bit positions, register word indices and reset values.
package cntdn_pkg;
    localparam int CNT_W      = 32;  // full counter and limit width
    localparam int NARROW_W   = 16;  // width used when the wide bit is clear
    localparam int CTRL_W     = 8;   // stored control byte
    localparam int IDX_W      = 3;   // register word index width
    localparam int PSC_W      = 8;   // prescaler depth (/256 needs 8 bits)
    localparam int PSC_MID_W  = 4;   // low prescaler bits that give /16

    localparam int CB_ONESHOT = 0;
    localparam int CB_WIDE    = 1;
    localparam int CB_PSC_LO  = 2;
    localparam int CB_IE      = 5;
    localparam int CB_PERIOD  = 6;
    localparam int CB_RUN     = 7;

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

    typedef enum logic [IDX_W-1:0] {
        IX_LOAD   = 3'd0,
        IX_COUNT  = 3'd1,
        IX_CTRL   = 3'd2,
        IX_CLEAR  = 3'd3,
        IX_RAW    = 3'd4,
        IX_MASKED = 3'd5,
        IX_DEFER  = 3'd6
    } reg_ix_e;

    // Active-width mask for a given control byte.
    function automatic logic [CNT_W-1:0] width_mask(input logic [CTRL_W-1:0] c);
        return c[CB_WIDE] ? {CNT_W{1'b1}}
                          : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

    // Value loaded into the counter for a control byte and a stored limit.
    function automatic logic [CNT_W-1:0] reload_of(input logic [CTRL_W-1:0] c,
                                                   input logic [CNT_W-1:0]  lim);
        logic free_run;
        free_run = !c[CB_ONESHOT] && !c[CB_PERIOD];
        return free_run ? width_mask(c) : (lim & width_mask(c));
    endfunction
endpackage

// File: rtl/cntdn_prescale.sv
// Module: tick prescaler.
// Counts base ticks while the timer runs and emits a one-cycle step at the
// selected division (/1, /16, /256; code 3 acts as /1).
// Assumes the /256 division needs exactly PSC_W bits, and that the clear
// input wins over a tick in the same cycle.
module cntdn_prescale
    import cntdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       step_o
);
    logic [PSC_W-1:0] phase_q;
    logic             wrap;

    // Advance the phase on each tick while running; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (clr_i)            phase_q <= '0;
        else if (tick_i && run_i)  phase_q <= phase_q + 1'b1;
    end

    // Decide whether the current tick completes a division period.
    always_comb begin
        case (sel_i)
            2'b01:   wrap = &phase_q[PSC_MID_W-1:0];
            2'b10:   wrap = &phase_q;
            default: wrap = 1'b1;
        endcase
    end

    assign step_o = tick_i && run_i && !clr_i && wrap;
endmodule

// File: rtl/cntdn_counter.sv
// Module: down-counter with reload and mode sequencing.
// Decrements on each step, flags expiry when a step meets an active count of
// 1 or 0, then reloads (periodic, free-running) or halts (one-shot).
// Assumes the load and control write strobes are mutually exclusive, since
// they come from one address decode.
module cntdn_counter
    import cntdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_q_i,
    input  logic [CNT_W-1:0]  limit_q_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              load_wr_i,
    input  logic              ctrl_wr_i,
    input  logic              step_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              halted_o,
    output logic              expire_o
);
    logic [CNT_W-1:0]  count_q;
    logic              halted_q;
    logic [CNT_W-1:0]  active;
    logic [CTRL_W-1:0] new_ctrl;

    assign new_ctrl = wdata_i[CTRL_W-1:0];
    assign active   = count_q & width_mask(ctrl_q_i);

    // An expiry is a step that sees the end of the count and is not pre-empted by a write.
    assign expire_o = step_i && ctrl_q_i[CB_RUN] && !halted_q && !load_wr_i &&
                      !ctrl_wr_i && (active <= CNT_W'(1));

    // Update the count: writes first, then the step-driven decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            halted_q <= 1'b0;
        end else if (load_wr_i) begin
            count_q  <= reload_of(ctrl_q_i, wdata_i);
            halted_q <= 1'b0;
        end else if (ctrl_wr_i) begin
            if (new_ctrl[CB_RUN]) count_q <= reload_of(new_ctrl, limit_q_i);
            halted_q <= 1'b0;
        end else if (expire_o) begin
            if (ctrl_q_i[CB_ONESHOT]) begin
                count_q  <= '0;
                halted_q <= 1'b1;
            end else begin
                count_q  <= reload_of(ctrl_q_i, limit_q_i);
            end
        end else if (step_i && ctrl_q_i[CB_RUN] && !halted_q) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count_o  = count_q;
    assign halted_o = halted_q;
endmodule

// File: rtl/cntdn_regs.sv
// Module: register decode, configuration storage, interrupt flag and read mux.
// Assumes addr_i is a word index and that reads have no side effects.
module cntdn_regs
    import cntdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              expire_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              raw_o,
    output logic              load_wr_o,
    output logic              ctrl_wr_o,
    output logic [CNT_W-1:0]  rdata_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  limit_q;
    logic              raw_q;
    logic              defer_wr;
    logic              clear_wr;

    assign load_wr_o = wr_en_i && (addr_i == IX_LOAD);
    assign ctrl_wr_o = wr_en_i && (addr_i == IX_CTRL);
    assign defer_wr  = wr_en_i && (addr_i == IX_DEFER);
    assign clear_wr  = wr_en_i && (addr_i == IX_CLEAR);

    // Store the control byte and the limit from either load register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            limit_q <= '0;
        end else begin
            if (ctrl_wr_o)             ctrl_q  <= wdata_i[CTRL_W-1:0];
            if (load_wr_o || defer_wr) limit_q <= wdata_i;
        end
    end

    // Hold the raw interrupt flag; an expiry outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw_q <= 1'b0;
        else if (expire_i) raw_q <= 1'b1;
        else if (clear_wr) raw_q <= 1'b0;
    end

    // Select read data by word index.
    always_comb begin
        case (addr_i)
            IX_LOAD, IX_DEFER: rdata_o = limit_q;
            IX_COUNT:          rdata_o = count_i & width_mask(ctrl_q);
            IX_CTRL:           rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            IX_RAW:            rdata_o = {{(CNT_W-1){1'b0}}, raw_q};
            IX_MASKED:         rdata_o = {{(CNT_W-1){1'b0}}, raw_q & ctrl_q[CB_IE]};
            default:           rdata_o = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign limit_o = limit_q;
    assign raw_o   = raw_q;
endmodule

// File: rtl/cntdn_timer.sv
// Module: top level of one programmable down-counter timer channel.
// Ties the register block, the prescaler and the counter together and
// drives the level interrupt.
// Assumes tick_i is synchronous to clk and at most one cycle per tick.
module cntdn_timer
    import cntdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  count_q;
    logic              raw_q;
    logic              halted_q;
    logic              load_wr;
    logic              ctrl_wr;
    logic              step;
    logic              expire;

    cntdn_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .count_i   (count_q),
        .expire_i  (expire),
        .ctrl_o    (ctrl_q),
        .limit_o   (limit_q),
        .raw_o     (raw_q),
        .load_wr_o (load_wr),
        .ctrl_wr_o (ctrl_wr),
        .rdata_o   (rdata_o)
    );

    cntdn_prescale u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (ctrl_q[CB_RUN]),
        .clr_i  (ctrl_wr),
        .sel_i  (ctrl_q[CB_PSC_LO+1:CB_PSC_LO]),
        .step_o (step)
    );

    cntdn_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_q_i  (ctrl_q),
        .limit_q_i (limit_q),
        .wdata_i   (wdata_i),
        .load_wr_i (load_wr),
        .ctrl_wr_i (ctrl_wr),
        .step_i    (step),
        .count_o   (count_q),
        .halted_o  (halted_q),
        .expire_o  (expire)
    );

    assign irq_o = raw_q & ctrl_q[CB_IE];
endmodule

// File: rtl/cntdn_checker.sv
// Module: property checker for the down-counter timer, bound into cntdn_timer.
module cntdn_checker
    import cntdn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  addr_i,
    input logic              wr_en_i,
    input logic [CNT_W-1:0]  wdata_i,
    input logic              irq_o,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              raw_q,
    input logic              halted_q,
    input logic              step,
    input logic              expire
);
    AST_RESET_CTRL: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_RST && !raw_q)); // R1

    AST_LOAD_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == IX_LOAD && ctrl_q[CB_PERIOD] && ctrl_q[CB_WIDE])
        |=> (count_q == $past(wdata_i))); // R2

    AST_DEFER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == IX_DEFER && !step) |=> $stable(count_q)); // R3

    AST_COUNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == IX_COUNT && !step) |=> $stable(count_q)); // R4

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !wr_en_i) |=> ($stable(count_q) && count_q == '0)); // R7

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == IX_CLEAR && !expire) |=> !raw_q); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(expire) || $past(wr_en_i && addr_i == IX_CTRL))); // R10
endmodule

bind cntdn_timer cntdn_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .ctrl_q   (ctrl_q),
    .count_q  (count_q),
    .raw_q    (raw_q),
    .halted_q (halted_q),
    .step     (step),
    .expire   (expire)
);

// File: tb/cntdn_timer_tb_top.sv
// Testbench: a vector table walked by one loop, then directed corner cases.
module cntdn_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = 32'h0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cntdn_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Vector fields: op[72:71] (0 write, 1 read-check, 2 ticks), index[70:68],
    // data or tick count[67:36], expected[35:4], requirement number[3:0].
    localparam int NV = 28;
    localparam logic [72:0] VEC [NV] = '{
        {2'd1, 3'd2, 32'h0,     32'h20,  4'd1},   // R1 control after reset
        {2'd1, 3'd1, 32'h0,     32'h0,   4'd1},   // R1 count after reset
        {2'd1, 3'd4, 32'h0,     32'h0,   4'd1},   // R1 raw after reset
        {2'd0, 3'd2, 32'h60,    32'h0,   4'd12},
        {2'd1, 3'd1, 32'h0,     32'h0,   4'd12},  // R12 stopped control write keeps count
        {2'd0, 3'd0, 32'h5,     32'h0,   4'd2},
        {2'd1, 3'd1, 32'h0,     32'h5,   4'd2},   // R2 immediate reload
        {2'd1, 3'd6, 32'h0,     32'h5,   4'd2},   // R2 both loads read the limit
        {2'd0, 3'd2, 32'hE0,    32'h0,   4'd12},
        {2'd2, 3'd0, 32'd3,     32'h0,   4'd5},
        {2'd1, 3'd1, 32'h0,     32'h2,   4'd5},   // R5 one per step
        {2'd1, 3'd4, 32'h0,     32'h0,   4'd9},   // R9 no expiry yet
        {2'd2, 3'd0, 32'd2,     32'h0,   4'd5},
        {2'd1, 3'd1, 32'h0,     32'h5,   4'd5},   // R5 periodic reload
        {2'd1, 3'd4, 32'h0,     32'h1,   4'd9},   // R9 expiry sets raw
        {2'd1, 3'd5, 32'h0,     32'h1,   4'd10},  // R10 masked follows raw
        {2'd0, 3'd3, 32'h0,     32'h0,   4'd9},
        {2'd1, 3'd4, 32'h0,     32'h0,   4'd9},   // R9 clear
        {2'd0, 3'd6, 32'h3,     32'h0,   4'd3},
        {2'd1, 3'd1, 32'h0,     32'h5,   4'd3},   // R3 count untouched
        {2'd1, 3'd0, 32'h0,     32'h3,   4'd3},   // R3 limit stored
        {2'd2, 3'd0, 32'd5,     32'h0,   4'd3},
        {2'd1, 3'd1, 32'h0,     32'h3,   4'd3},   // R3 used at next reload
        {2'd0, 3'd1, 32'h1234,  32'h0,   4'd4},
        {2'd1, 3'd1, 32'h0,     32'h3,   4'd4},   // R4 count write ignored
        {2'd1, 3'd7, 32'h0,     32'h0,   4'd13},  // R13 unused index
        {2'd1, 3'd3, 32'h0,     32'h0,   4'd13},  // R13 clear index reads 0
        {2'd0, 3'd3, 32'h0,     32'h0,   4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] ix, input logic [31:0] d);
        @(negedge clk);
        addr_i = ix; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] ix, input logic [31:0] exp, input string tag);
        addr_i = ix;
        #1;
        check(tag, rdata_o, exp);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_i = 1'b1;
            repeat (n) @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [72:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (v[72:71])
                2'd0: wr_reg(v[70:68], v[67:36]);
                2'd1: rd_chk(v[70:68], v[35:4], $sformatf("R%0d vector %0d", v[3:0], i));
                default: ticks(int'(v[67:36]));
            endcase
        end

        // R6: free-running 16-bit ignores the limit and wraps to 0xFFFF.
        wr_reg(3'd0, 32'h9);
        wr_reg(3'd2, 32'hA0);
        rd_chk(3'd1, 32'hFFFF, "R6 free16 start");
        ticks(65534);
        rd_chk(3'd1, 32'h1, "R6 free16 near end");
        rd_chk(3'd4, 32'h0, "R9 no early expiry");
        ticks(1);
        rd_chk(3'd1, 32'hFFFF, "R6 free16 reload");
        rd_chk(3'd4, 32'h1, "R9 free16 expiry");
        check("R10 irq with enable", {31'h0, irq_o}, 32'h1);

        // R6: free-running 32-bit.
        wr_reg(3'd2, 32'hA2);
        rd_chk(3'd1, 32'hFFFFFFFF, "R6 free32 start");
        ticks(2);
        rd_chk(3'd1, 32'hFFFFFFFD, "R6 free32 decrement");

        // R10: masking by the enable bit.
        wr_reg(3'd2, 32'h02);
        rd_chk(3'd5, 32'h0, "R10 masked off");
        check("R10 irq masked", {31'h0, irq_o}, 32'h0);
        rd_chk(3'd4, 32'h1, "R10 raw kept");
        wr_reg(3'd2, 32'h22);
        check("R10 irq unmasked", {31'h0, irq_o}, 32'h1);
        wr_reg(3'd3, 32'h0);

        // R7: one-shot halts at zero.
        wr_reg(3'd2, 32'h21);
        wr_reg(3'd0, 32'h3);
        wr_reg(3'd2, 32'hA1);
        ticks(3);
        rd_chk(3'd1, 32'h0, "R7 one-shot reaches zero");
        rd_chk(3'd4, 32'h1, "R7 one-shot expiry");
        wr_reg(3'd3, 32'h0);
        ticks(5);
        rd_chk(3'd1, 32'h0, "R7 stays halted");
        rd_chk(3'd4, 32'h0, "R7 no second expiry");

        // R8: prescaler divisions and phase restart.
        wr_reg(3'd2, 32'h60);
        wr_reg(3'd0, 32'h2);
        wr_reg(3'd2, 32'hE4);
        ticks(15);
        rd_chk(3'd1, 32'h2, "R8 div16 before step");
        ticks(1);
        rd_chk(3'd1, 32'h1, "R8 div16 step");
        ticks(10);
        wr_reg(3'd2, 32'hE4);
        ticks(15);
        rd_chk(3'd1, 32'h2, "R8 phase restarted");
        ticks(1);
        rd_chk(3'd1, 32'h1, "R8 div16 after restart");
        wr_reg(3'd2, 32'hE8);
        ticks(255);
        rd_chk(3'd1, 32'h2, "R8 div256 before step");
        ticks(1);
        rd_chk(3'd1, 32'h1, "R8 div256 step");
        wr_reg(3'd2, 32'hEC);
        ticks(1);
        rd_chk(3'd1, 32'h1, "R8 code 3 divides by one");

        // R11: 16-bit mode uses only the low limit bits.
        wr_reg(3'd2, 32'h60);
        wr_reg(3'd0, 32'h12345);
        rd_chk(3'd1, 32'h2345, "R11 narrow reload");
        rd_chk(3'd0, 32'h12345, "R11 limit kept in full");

        // R9: expiry and clear in the same cycle leave the flag set.
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd2, 32'hE0);
        wr_reg(3'd3, 32'h0);
        @(negedge clk);
        tick_i = 1'b1; addr_i = 3'd3; wr_en_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rd_chk(3'd4, 32'h1, "R9 expiry beats clear");
        rd_chk(3'd1, 32'h1, "R5 limit one reloads");

        // R1: reset while running.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd_chk(3'd2, 32'h20, "R1 control after mid-run reset");
        rd_chk(3'd1, 32'h0, "R1 count after mid-run reset");
        check("R1 irq after mid-run reset", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule